// File: doc/BRIEF.md
# Watchdog Timer with Reset Grace Window

This block guards a system against software that stops servicing it. A counter advances on every watchdog clock strobe while the block is enabled. When it reaches the selected interval, a time-out is recorded in a status flag that can raise an interrupt, and it can also wake the system from power-down. If the reset function is enabled, a grace window of selectable length then opens. Software can still cancel the pending reset during this window by clearing the counter. If the window expires first, a reset request pulse of fixed length is sent to the system.

Software reaches the block through a simple word-wide register port with three registers: control at offset 0x0, interrupt enable at offset 0x4 and status at offset 0x8. Reads return data one cycle after the read strobe. Most control fields are guarded and only accept writes while the unlock input is high. The watchdog clock arrives as a single-cycle tick strobe that is already in the bus clock domain. A debug input can freeze the count, and a power-down input qualifies wake-up.

Top module: `wdog_grace`

## Requirements
- R1: After synchronous reset, all three registers read 0, and the interrupt, wake and reset request outputs are low.
- R2: A control write made while the unlock input is low changes only the grace select field (bits 9:8). The counter clear (bit 0), reset enable (bit 1), wake enable (bit 2), run enable (bit 3), interval select (bits 6:4) and debug-run (bit 31) fields keep their values.
- R3: With interval select n, a time-out occurs after exactly 2^(4+2n) ticks, counted from the point where the counter was zero.
- R4: Every time-out sets status bit 0, whatever the interrupt enable says. The interrupt output equals status bit 0 ANDed with interrupt-enable bit 0.
- R5: With reset enable set, the reset request rises a number of ticks after the time-out given by the grace select field: 00 gives 1026, 01 gives 130, 10 gives 18 and 11 gives 3.
- R6: The reset request stays high for exactly 4 ticks. Firing it sets status bit 1 and returns the grace select field to 00.
- R7: Writing 1 to control bit 0 while unlocked zeroes the counter and cancels a pending reset, and the bit reads back as 0 afterwards. Clearing the run enable also zeroes the counter.
- R8: While the reset enable is 0, the reset request never rises and status bit 1 stays 0.
- R9: A time-out that occurs while power-down is high and wake enable is set also sets status bit 2, and the wake output follows that bit. With power-down low, status bit 2 stays 0.
- R10: With control bit 31 at 0, the count holds while the debug input is high. With bit 31 at 1, the count keeps running while debug is high.
- R11: Writing 1 to a status bit clears it. A time-out in the same cycle as a clearing write to bit 0 leaves bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Watchdog clock strobe, one cycle per watchdog clock |
| unlock_i | input | 1 | Write permission for guarded control fields |
| dbg_i | input | 1 | System is in debug mode |
| pd_i | input | 1 | System is in power-down |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Time-out interrupt |
| wake_o | output | 1 | Wake-up request |
| sysrst_o | output | 1 | System reset request pulse |

## Verification
Two things can land on the same clock edge: a time-out setting the time-out flag, and a software write that clears that flag. The bench provokes this by counting ticks from the enable write, so that the status write falls exactly on the 16th tick. It then reads the flag back and expects it to still be set. A second clearing write a few cycles later, with no time-out pending, must then read back 0, which shows that the first write was not simply ignored.

// File: rtl/wdog_grace_pkg.sv
package wdog_grace_pkg;

  localparam int BUS_W  = 32;
  localparam int ISEL_W = 3;
  localparam int DSEL_W = 2;

  // register byte offsets
  localparam int CTRL_OFS = 'h0;
  localparam int IEN_OFS  = 'h4;
  localparam int STAT_OFS = 'h8;

  // control field positions
  localparam int B_CLR    = 0;
  localparam int B_RSTEN  = 1;
  localparam int B_WKEN   = 2;
  localparam int B_EN     = 3;
  localparam int B_ISEL   = 4;
  localparam int B_DSEL   = 8;
  localparam int B_DBGRUN = 31;

  // status / enable positions
  localparam int B_IEN  = 0;
  localparam int S_TOF  = 0;
  localparam int S_RSTF = 1;
  localparam int S_WKF  = 2;

  typedef struct packed {
    logic              dbg_run;
    logic [DSEL_W-1:0] dsel;
    logic [ISEL_W-1:0] isel;
    logic              en;
    logic              wken;
    logic              rsten;
    logic              clr;
  } ctrl_t;

  typedef struct packed {
    logic wkf;
    logic rstf;
    logic tof;
  } flags_t;

endpackage

// File: rtl/wdog_grace_regs.sv
module wdog_grace_regs
  import wdog_grace_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unlock_i,
  input  logic              pd_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              tmo_i,
  input  logic              fire_i,
  output ctrl_t             ctrl_o,
  output logic              ien_o,
  output flags_t            flags_o
);

  logic sel_ctrl, sel_ien, sel_stat;
  logic wr_ctrl, wr_ien, wr_stat;
  logic [BUS_W-1:0] rd_mux;
  logic unused_wbits;

  assign sel_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
  assign sel_ien  = (addr_i == ADDR_W'(IEN_OFS));
  assign sel_stat = (addr_i == ADDR_W'(STAT_OFS));
  assign wr_ctrl  = wr_i & sel_ctrl;
  assign wr_ien   = wr_i & sel_ien;
  assign wr_stat  = wr_i & sel_stat;

  assign unused_wbits = ^{wdata_i[30:10], wdata_i[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o  <= '0;
      ien_o   <= 1'b0;
      flags_o <= '0;
      rdata_o <= '0;
    end else begin
      ctrl_o.clr <= 1'b0;
      if (wr_ctrl) begin
        ctrl_o.dsel <= wdata_i[B_DSEL +: DSEL_W];
        if (unlock_i) begin
          ctrl_o.clr     <= wdata_i[B_CLR];
          ctrl_o.rsten   <= wdata_i[B_RSTEN];
          ctrl_o.wken    <= wdata_i[B_WKEN];
          ctrl_o.en      <= wdata_i[B_EN];
          ctrl_o.isel    <= wdata_i[B_ISEL +: ISEL_W];
          ctrl_o.dbg_run <= wdata_i[B_DBGRUN];
        end
      end
      if (fire_i) ctrl_o.dsel <= '0;
      if (wr_ien) ien_o <= wdata_i[B_IEN];
      // hardware set takes priority over a same-cycle clear
      flags_o.tof  <= (flags_o.tof  & ~(wr_stat & wdata_i[S_TOF]))  | tmo_i;
      flags_o.rstf <= (flags_o.rstf & ~(wr_stat & wdata_i[S_RSTF])) | fire_i;
      flags_o.wkf  <= (flags_o.wkf  & ~(wr_stat & wdata_i[S_WKF]))
                    | (tmo_i & pd_i & ctrl_o.wken);
      if (rd_i) rdata_o <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[B_CLR]              = ctrl_o.clr;
      rd_mux[B_RSTEN]            = ctrl_o.rsten;
      rd_mux[B_WKEN]             = ctrl_o.wken;
      rd_mux[B_EN]               = ctrl_o.en;
      rd_mux[B_ISEL +: ISEL_W]   = ctrl_o.isel;
      rd_mux[B_DSEL +: DSEL_W]   = ctrl_o.dsel;
      rd_mux[B_DBGRUN]           = ctrl_o.dbg_run;
    end else if (sel_ien) begin
      rd_mux[B_IEN] = ien_o;
    end else if (sel_stat) begin
      rd_mux[S_TOF]  = flags_o.tof;
      rd_mux[S_RSTF] = flags_o.rstf;
      rd_mux[S_WKF]  = flags_o.wkf;
    end
  end

endmodule

// File: rtl/wdog_grace_tick.sv
module wdog_grace_tick
  import wdog_grace_pkg::*;
#(
  parameter int IVL_BASE = 4,
  parameter int IVL_STEP = 2,
  parameter int CNT_W    = IVL_BASE + IVL_STEP * ((1 << ISEL_W) - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              fire_i,
  input  logic [ISEL_W-1:0] isel_i,
  output logic              tmo_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam int NSEL = 1 << ISEL_W;

  logic [CNT_W-1:0] term [NSEL];
  logic             hit;

  // terminal count per interval select: 2^(BASE+STEP*g) - 1
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    localparam int SH = IVL_BASE + IVL_STEP * g;
    assign term[g] = {CNT_W{1'b1}} >> (CNT_W - SH);
  end

  assign hit   = (cnt_o == term[isel_i]);
  assign tmo_o = act_i & hit & ~clr_i & ~fire_i;

  always_ff @(posedge clk) begin
    if (rst || !en_i || clr_i || fire_i) begin
      cnt_o <= '0;
    end else if (act_i) begin
      cnt_o <= hit ? '0 : cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_grace_seq.sv
module wdog_grace_seq
  import wdog_grace_pkg::*;
#(
  parameter int DLY_0     = 1026,
  parameter int DLY_1     = 130,
  parameter int DLY_2     = 18,
  parameter int DLY_3     = 3,
  parameter int RST_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              act_i,
  input  logic              abort_i,
  input  logic              tmo_i,
  input  logic [DSEL_W-1:0] dsel_i,
  output logic              fire_o,
  output logic              pulse_o
);

  localparam int NDLY = 1 << DSEL_W;
  localparam int DLY_TAB [NDLY] = '{DLY_0, DLY_1, DLY_2, DLY_3};
  localparam int DLY_MAX = (DLY_0 > DLY_1 ? DLY_0 : DLY_1) > (DLY_2 > DLY_3 ? DLY_2 : DLY_3)
                         ? (DLY_0 > DLY_1 ? DLY_0 : DLY_1) : (DLY_2 > DLY_3 ? DLY_2 : DLY_3);
  localparam int DCW = (DLY_MAX > 1) ? $clog2(DLY_MAX) : 1;
  localparam int PCW = $clog2(RST_TICKS) + 1;

  logic [DCW-1:0] dterm [NDLY];
  logic [DCW-1:0] dcnt;
  logic [PCW-1:0] pcnt;
  logic           pend;
  logic           start;

  for (genvar g = 0; g < NDLY; g++) begin : g_dly
    assign dterm[g] = DCW'(DLY_TAB[g] - 1);
  end

  assign start  = tmo_i & ~abort_i & ~pend;
  assign fire_o = pend & act_i & ~abort_i & (dcnt == dterm[dsel_i]);

  // grace window
  always_ff @(posedge clk) begin
    if (rst || abort_i || fire_o) begin
      pend <= 1'b0;
      dcnt <= '0;
    end else if (start) begin
      pend <= 1'b1;
      dcnt <= '0;
    end else if (pend && act_i) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  // fixed-length request pulse, counted on raw ticks
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      pcnt    <= '0;
    end else if (fire_o) begin
      pulse_o <= 1'b1;
      pcnt    <= '0;
    end else if (pulse_o && tick_i) begin
      if (pcnt == PCW'(RST_TICKS - 1)) pulse_o <= 1'b0;
      else                             pcnt    <= pcnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_grace.sv
module wdog_grace
  import wdog_grace_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int IVL_BASE  = 4,
  parameter int IVL_STEP  = 2,
  parameter int DLY_0     = 1026,
  parameter int DLY_1     = 130,
  parameter int DLY_2     = 18,
  parameter int DLY_3     = 3,
  parameter int RST_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              unlock_i,
  input  logic              dbg_i,
  input  logic              pd_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              sysrst_o
);

  localparam int CNT_W = IVL_BASE + IVL_STEP * ((1 << ISEL_W) - 1);

  ctrl_t            ctrl;
  flags_t           flags;
  logic             ien;
  logic             freeze, act, abort;
  logic             tmo_ev, fire_ev;
  logic [CNT_W-1:0] cnt_w;

  assign freeze = dbg_i & ~ctrl.dbg_run;
  assign act    = tick_i & ctrl.en & ~freeze;
  assign abort  = ctrl.clr | ~ctrl.en | ~ctrl.rsten;

  wdog_grace_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .unlock_i (unlock_i),
    .pd_i     (pd_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .tmo_i    (tmo_ev),
    .fire_i   (fire_ev),
    .ctrl_o   (ctrl),
    .ien_o    (ien),
    .flags_o  (flags)
  );

  wdog_grace_tick #(
    .IVL_BASE (IVL_BASE),
    .IVL_STEP (IVL_STEP),
    .CNT_W    (CNT_W)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .act_i  (act),
    .en_i   (ctrl.en),
    .clr_i  (ctrl.clr),
    .fire_i (fire_ev),
    .isel_i (ctrl.isel),
    .tmo_o  (tmo_ev),
    .cnt_o  (cnt_w)
  );

  wdog_grace_seq #(
    .DLY_0     (DLY_0),
    .DLY_1     (DLY_1),
    .DLY_2     (DLY_2),
    .DLY_3     (DLY_3),
    .RST_TICKS (RST_TICKS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .act_i   (act),
    .abort_i (abort),
    .tmo_i   (tmo_ev),
    .dsel_i  (ctrl.dsel),
    .fire_o  (fire_ev),
    .pulse_o (sysrst_o)
  );

  assign irq_o  = flags.tof & ien;
  assign wake_o = flags.wkf;

endmodule

// File: rtl/wdog_grace_chk.sv
module wdog_grace_chk (
  input logic        clk,
  input logic        rst,
  input logic        tmo,
  input logic        fire,
  input logic        clr,
  input logic        en,
  input logic        rsten,
  input logic        wken,
  input logic        freeze,
  input logic        pd,
  input logic        tof,
  input logic        rstf,
  input logic        wkf,
  input logic [1:0]  dsel,
  input logic [31:0] cnt,
  input logic        irq,
  input logic        wake,
  input logic        sysrst
);

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!irq && !wake && !sysrst));

  assert_tmo_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    tmo |=> tof);

  assert_fire_effects_R6: assert property (@(posedge clk) disable iff (rst)
    fire |=> (sysrst && rstf && dsel == 2'b00));

  assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == 32'd0));

  assert_no_reset_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!rsten && !sysrst) |=> !sysrst);

  assert_no_rstf_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!rsten && !rstf) |=> !rstf);

  assert_wake_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (tmo && pd && wken) |=> (wkf && tof));

  assert_freeze_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (freeze && en && !clr) |=> $stable(cnt));

endmodule

bind wdog_grace wdog_grace_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .tmo    (tmo_ev),
  .fire   (fire_ev),
  .clr    (ctrl.clr),
  .en     (ctrl.en),
  .rsten  (ctrl.rsten),
  .wken   (ctrl.wken),
  .freeze (freeze),
  .pd     (pd_i),
  .tof    (flags.tof),
  .rstf   (flags.rstf),
  .wkf    (flags.wkf),
  .dsel   (ctrl.dsel),
  .cnt    (32'(cnt_w)),
  .irq    (irq_o),
  .wake   (wake_o),
  .sysrst (sysrst_o)
);

// File: tb/wdog_grace_test.sv
module wdog_grace_test;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_IEN  = 4'h4;
  localparam logic [3:0] A_STAT = 4'h8;

  // vectors: interval select, grace select, expected time-out ticks, expected grace ticks
  localparam int NV = 6;
  localparam int V_ISEL [NV] = '{0, 0, 1, 2, 0, 3};
  localparam int V_DSEL [NV] = '{3, 2, 3, 1, 0, 3};
  localparam int V_TMO  [NV] = '{16, 16, 64, 256, 16, 1024};
  localparam int V_DLY  [NV] = '{3, 18, 3, 130, 1026, 3};

  logic        clk = 1'b0;
  logic        rst, tick, unlock, dbg, pd, bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, rdata;
  logic        irq, wake, sysrst;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wdog_grace uut (
    .clk (clk), .rst (rst), .tick_i (tick), .unlock_i (unlock),
    .dbg_i (dbg), .pd_i (pd), .bus_wr_i (bus_wr), .bus_rd_i (bus_rd),
    .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata), .bus_rdata_o (rdata),
    .irq_o (irq), .wake_o (wake), .sysrst_o (sysrst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit clr, bit rsten, bit wken, bit en,
                                     int isel, int dsel, bit dbgrun);
    return {dbgrun, 21'b0, 2'(dsel), 1'b0, 3'(isel), en, wken, rsten, clr};
  endfunction

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic unl);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; unlock = unl;
    @(negedge clk);
    bus_wr = 1'b0; unlock = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata;
  endtask

  // counts negedges until the chosen output is high; -1 if it never rises
  task automatic wait_hi(input bit use_rst, output int n);
    n = 0;
    forever begin
      step(1);
      n++;
      if (use_rst ? sysrst : irq) break;
      if (n > 5000) begin n = -1; break; end
    end
  endtask

  task automatic cleanup();
    wr(A_CTRL, 32'h0, 1'b1);
    wr(A_STAT, 32'h7, 1'b0);
    wr(A_IEN, 32'h0, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, m, w, hi;
    rst = 1'b1; tick = 1'b1; unlock = 1'b0; dbg = 1'b0; pd = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(4);
    rst = 1'b0;
    step(1);

    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wake", 32'(wake), 0);
    chk("R1 sysrst", 32'(sysrst), 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_IEN, d);  chk("R1 ien", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);

    // table walk: R3 interval, R5 grace, R6 pulse and side effects
    for (int i = 0; i < NV; i++) begin
      cleanup();
      wr(A_IEN, 32'h1, 1'b0);
      wr(A_CTRL, mk(0, 1, 0, 1, V_ISEL[i], V_DSEL[i], 0), 1'b1);
      wait_hi(1'b0, n); chk("R3 time-out ticks", 32'(n), 32'(V_TMO[i]));
      wait_hi(1'b1, m); chk("R5 grace ticks", 32'(m), 32'(V_DLY[i]));
      w = 1;
      while (sysrst && w < 100) begin step(1); if (sysrst) w++; end
      chk("R6 pulse width", 32'(w), 4);
      rd(A_STAT, d); chk("R6 R4 status flags", d & 32'h3, 3);
      rd(A_CTRL, d); chk("R6 grace select cleared", (d >> 8) & 32'h3, 0);
    end

    // R2: guarded fields ignore locked writes
    cleanup();
    wr(A_CTRL, mk(0, 1, 1, 1, 5, 2, 1), 1'b0);
    rd(A_CTRL, d); chk("R2 locked write", d, 32'h0000_0200);
    wr(A_CTRL, mk(0, 1, 1, 1, 5, 2, 1), 1'b1);
    rd(A_CTRL, d); chk("R2 unlocked write", d, 32'h8000_025E);

    // R4 and R8: flag without interrupt enable, no reset when disabled
    cleanup();
    wr(A_CTRL, mk(0, 0, 0, 1, 0, 3, 0), 1'b1);
    step(20);
    chk("R4 irq gated off", 32'(irq), 0);
    hi = 0;
    for (int k = 0; k < 60; k++) begin step(1); if (sysrst) hi++; end
    chk("R8 no reset request", 32'(hi), 0);
    rd(A_STAT, d); chk("R4 R8 status", d, 1);

    // R7: clear during grace aborts reset
    cleanup();
    wr(A_IEN, 32'h1, 1'b0);
    wr(A_CTRL, mk(0, 1, 0, 1, 0, 2, 0), 1'b1);
    wait_hi(1'b0, n); chk("R7 setup time-out", 32'(n), 16);
    step(5);
    wr(A_CTRL, mk(1, 1, 0, 1, 0, 2, 0), 1'b1);
    hi = 0;
    for (int k = 0; k < 30; k++) begin step(1); if (sysrst) hi++; end
    chk("R7 reset aborted", 32'(hi), 0);
    rd(A_CTRL, d); chk("R7 clear bit self-clears", d & 32'h1, 0);
    rd(A_STAT, d); chk("R7 no reset flag", d & 32'h2, 0);

    // R7: disabling zeroes the counter
    cleanup();
    wr(A_IEN, 32'h1, 1'b0);
    wr(A_CTRL, mk(0, 0, 0, 1, 0, 0, 0), 1'b1);
    step(10);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 0, 0), 1'b1);
    wr(A_CTRL, mk(0, 0, 0, 1, 0, 0, 0), 1'b1);
    wait_hi(1'b0, n); chk("R7 restart after disable", 32'(n), 16);

    // R9: wake-up in power-down
    cleanup();
    pd = 1'b1;
    wr(A_CTRL, mk(0, 0, 1, 1, 0, 0, 0), 1'b1);
    step(17);
    chk("R9 wake output", 32'(wake), 1);
    rd(A_STAT, d); chk("R9 wake and time-out flags", d, 5);
    cleanup();
    pd = 1'b0;
    wr(A_CTRL, mk(0, 0, 1, 1, 0, 0, 0), 1'b1);
    step(17);
    chk("R9 no wake when awake", 32'(wake), 0);
    rd(A_STAT, d); chk("R9 status awake", d, 1);

    // R10: debug freeze and debug run
    cleanup();
    wr(A_IEN, 32'h1, 1'b0);
    dbg = 1'b1;
    wr(A_CTRL, mk(0, 0, 0, 1, 0, 0, 0), 1'b1);
    step(50);
    chk("R10 frozen in debug", 32'(irq), 0);
    dbg = 1'b0;
    wait_hi(1'b0, n); chk("R10 resumes from zero", 32'(n), 16);
    cleanup();
    wr(A_IEN, 32'h1, 1'b0);
    dbg = 1'b1;
    wr(A_CTRL, mk(0, 0, 0, 1, 0, 0, 1), 1'b1);
    wait_hi(1'b0, n); chk("R10 runs in debug", 32'(n), 16);
    dbg = 1'b0;

    // R11: set wins over same-cycle clear, then clear works
    cleanup();
    wr(A_CTRL, mk(0, 0, 0, 1, 0, 0, 0), 1'b1);
    step(15);
    wr(A_STAT, 32'h1, 1'b0);
    rd(A_STAT, d); chk("R11 set beats clear", d & 32'h1, 1);
    wr(A_STAT, 32'h1, 1'b0);
    rd(A_STAT, d); chk("R11 clear by write", d & 32'h1, 0);
    wr(A_CTRL, 32'h0, 1'b1);
    wr(A_STAT, 32'h7, 1'b0);
    rd(A_STAT, d); chk("R11 all flags cleared", d, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule